// File: doc/BRIEF.md
# Byte-Reversible Load/Store Unit

This unit carries out one byte, halfword or word memory access at a time for a 32-bit big-endian core. The core hands over an effective address, a size code, a load or store flag, a reverse flag, a destination register index and the store data. The unit turns that into a single request on a simple memory port (address, byte enables, write data), waits for the acknowledge, and then reports one of three outcomes: a register writeback of the zero-extended load value, a memory-fault exception, or a misalignment exception.

Reversed accesses let software read and write little-endian structures. The unit flips the low address bits of a sub-word access and swaps the bytes of multi-byte data. The memory access is always issued before alignment is judged, so a fault returned by memory hides any misalignment of the same access. Alignment checking is a build-time option.

Top module: `rev_lsu`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `mem_req`, `done`, `wb_en` and `exc_valid` are all low.
- R2: The size codes are 0 for byte, 1 for halfword and 2 for word, and loads are zero-extended. Byte offset k of a word sits on data bits [31-8k:24-8k], and `mem_be[i]` enables data bits [8i+7:8i]. A byte access enables only the lane of address bits [1:0]. A halfword access enables lanes 0-1 when address bit 1 is 0 and lanes 2-3 when it is 1. A word access enables all four lanes.
- R3: A reversed byte access uses the address XOR 3. A reversed halfword access uses the address XOR 2. A reversed word access leaves the address unchanged. `mem_addr` carries the adjusted address.
- R4: A reversed halfword or word access swaps the byte order of the data in both directions. Offset base+k then carries data byte k, counted from the least significant byte.
- R5: A request is taken only when the unit is idle. `mem_req` and its address, enables and data stay stable until `mem_ack`. `busy` is high from the cycle after acceptance until the result cycle. A request raised while busy is ignored and causes no second memory access.
- R6: When memory returns `mem_fault`, the unit raises an exception with `exc_align`=0 and performs no writeback. This holds even if the access is also misaligned.
- R7: With alignment checking on, a halfword or word access with (adjusted address AND (2^size-1)) nonzero raises an exception with `exc_align`=1 once memory has answered without fault. The exception reports the destination index, the store flag and the mask (1 for halfword, 3 for word). A misaligned load performs no writeback. A misaligned store has already been written.
- R8: A load writes back only when there was no exception and the destination index is nonzero. A load to index 0 completes with no writeback.
- R9: Byte accesses never raise a misalignment exception.
- R10: `done` is a one-cycle pulse in the cycle after the acknowledge. `wb_en` and `exc_valid` appear only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request, taken when idle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_rev | input | 1 | Byte-reversed access |
| req_addr | input | AW | Effective address |
| req_rd | input | RW | Destination register index |
| req_wdata | input | 32 | Store data, right-aligned |
| busy | output | 1 | Access in flight |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Adjusted byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_ack | input | 1 | Memory response |
| mem_fault | input | 1 | Response carries a fault |
| mem_rdata | input | 32 | Read word |
| done | output | 1 | Result cycle pulse |
| wb_en | output | 1 | Register writeback |
| wb_idx | output | RW | Writeback register index |
| wb_data | output | 32 | Zero-extended load value |
| exc_valid | output | 1 | Exception raised |
| exc_align | output | 1 | 1 misalignment, 0 memory fault |
| exc_store | output | 1 | Excepting access was a store |
| exc_rd | output | RW | Register index of the excepting access |
| exc_mask | output | 2 | Size mask of the excepting access |

## Verification
Memory-fault reporting and misalignment detection can both apply to the same access. The bench provokes this with halfword and word accesses at odd or unaligned offsets inside a region that its memory model answers with a fault. It then judges that only the fault is reported, with `exc_align` low and no writeback. Reversal and misalignment also meet: a reversed halfword at an odd address is flipped by XOR 2 and stays misaligned. The bench expects the exception on the adjusted address after the store has already landed.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } lsu_state_e;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [DATA_W-1:0] swap32(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) begin
      r[8*i +: 8] = v[8*(LANES-1-i) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0]     addr,
  input  size_e             size,
  input  logic              rev,
  input  logic [DATA_W-1:0] wdata,
  output logic [AW-1:0]     paddr,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wlanes
);

  logic [1:0]        flip;
  logic [1:0]        lane;
  logic [15:0]       half_d;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    flip = 2'b00;
    if (rev) begin
      unique case (size)
        SZ_BYTE: flip = 2'd3;
        SZ_HALF: flip = 2'd2;
        default: flip = 2'd0;
      endcase
    end
    lane  = addr[1:0] ^ flip;
    paddr = {addr[AW-1:2], lane};
  end

  always_comb begin
    half_d = rev ? swap16(wdata[15:0]) : wdata[15:0];
    word_d = rev ? swap32(wdata) : wdata;
    unique case (size)
      SZ_BYTE: begin
        be     = 4'b1000 >> lane;
        wlanes = {4{wdata[7:0]}};
      end
      SZ_HALF: begin
        be     = lane[1] ? 4'b0011 : 4'b1100;
        wlanes = {2{half_d}};
      end
      default: begin
        be     = 4'b1111;
        wlanes = word_d;
      end
    endcase
  end

endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
(
  input  logic [DATA_W-1:0] rdata,
  input  logic [1:0]        lane,
  input  size_e             size,
  input  logic              rev,
  output logic [DATA_W-1:0] value
);

  logic [DATA_W-1:0] shifted;
  logic [15:0]       half_s;

  always_comb begin
    shifted = rdata >> {~lane, 3'b000};
    half_s  = lane[1] ? rdata[15:0] : rdata[31:16];
    unique case (size)
      SZ_BYTE: value = {24'd0, shifted[7:0]};
      SZ_HALF: value = {16'd0, rev ? swap16(half_s) : half_s};
      default: value = rev ? swap32(rdata) : rdata;
    endcase
  end

endmodule

// File: rtl/lsu_misalign.sv
module lsu_misalign
  import lsu_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input  size_e      size,
  input  logic [1:0] lane,
  output logic [1:0] mask,
  output logic       mis
);

  always_comb begin
    unique case (size)
      SZ_BYTE: mask = 2'b00;
      SZ_HALF: mask = 2'b01;
      default: mask = 2'b11;
    endcase
  end

  generate
    if (ENABLE) begin : g_chk
      assign mis = |(lane & mask);
    end else begin : g_nochk
      assign mis = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/rev_lsu.sv
module rev_lsu
  import lsu_pkg::*;
#(
  parameter int AW        = 32,
  parameter int RW        = 5,
  parameter bit ALIGN_CHK = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_rev,
  input  logic [AW-1:0]     req_addr,
  input  logic [RW-1:0]     req_rd,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_fault,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              wb_en,
  output logic [RW-1:0]     wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              exc_valid,
  output logic              exc_align,
  output logic              exc_store,
  output logic [RW-1:0]     exc_rd,
  output logic [1:0]        exc_mask
);

  lsu_state_e        state_q;
  size_e             op_size;
  logic              op_rev;
  logic              op_store;
  logic [RW-1:0]     op_rd;

  logic [AW-1:0]     paddr_c;
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] wl_c;
  logic [DATA_W-1:0] ld_c;
  logic [1:0]        mask_c;
  logic              mis_c;

  lsu_lane_map #(.AW(AW)) u_map (
    .addr   (req_addr),
    .size   (size_e'(req_size)),
    .rev    (req_rev),
    .wdata  (req_wdata),
    .paddr  (paddr_c),
    .be     (be_c),
    .wlanes (wl_c)
  );

  lsu_load_fmt u_fmt (
    .rdata (mem_rdata),
    .lane  (mem_addr[1:0]),
    .size  (op_size),
    .rev   (op_rev),
    .value (ld_c)
  );

  lsu_misalign #(.ENABLE(ALIGN_CHK)) u_mis (
    .size (op_size),
    .lane (mem_addr[1:0]),
    .mask (mask_c),
    .mis  (mis_c)
  );

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      op_size   <= SZ_BYTE;
      op_rev    <= 1'b0;
      op_store  <= 1'b0;
      op_rd     <= '0;
      done      <= 1'b0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      exc_valid <= 1'b0;
      exc_align <= 1'b0;
      exc_store <= 1'b0;
      exc_rd    <= '0;
      exc_mask  <= '0;
    end else begin
      done      <= 1'b0;
      wb_en     <= 1'b0;
      exc_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            state_q   <= ST_WAIT;
            mem_req   <= 1'b1;
            mem_we    <= req_store;
            mem_addr  <= paddr_c;
            mem_be    <= be_c;
            mem_wdata <= wl_c;
            op_size   <= size_e'(req_size);
            op_rev    <= req_rev;
            op_store  <= req_store;
            op_rd     <= req_rd;
          end
        end
        default: begin
          if (mem_ack) begin
            state_q <= ST_IDLE;
            mem_req <= 1'b0;
            done    <= 1'b1;
            if (mem_fault || mis_c) begin
              exc_valid <= 1'b1;
              exc_align <= !mem_fault;
              exc_store <= op_store;
              exc_rd    <= op_rd;
              exc_mask  <= mask_c;
            end else if (!op_store && op_rd != '0) begin
              wb_en   <= 1'b1;
              wb_idx  <= op_rd;
              wb_data <= ld_c;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/rev_lsu_chk.sv
module rev_lsu_chk #(
  parameter int AW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be,
  input logic          done,
  input logic          wb_en,
  input logic [RW-1:0] wb_idx,
  input logic          exc_valid,
  input logic          exc_align,
  input logic [1:0]    exc_mask
);

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !mem_req && !done && !wb_en && !exc_valid));

  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be)));

  p_req_busy_r5: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  p_lane_shape_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || mem_be == 4'hF));

  p_wb_clean_r8: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (!exc_valid && wb_idx != '0));

  p_align_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_align) |-> (exc_mask != 2'b00));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_in_done_r10: assert property (@(posedge clk) disable iff (rst)
    (wb_en || exc_valid) |-> (done && !busy));

endmodule

bind rev_lsu rev_lsu_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .done      (done),
  .wb_en     (wb_en),
  .wb_idx    (wb_idx),
  .exc_valid (exc_valid),
  .exc_align (exc_align),
  .exc_mask  (exc_mask)
);

// File: tb/rev_lsu_bench.sv
`timescale 1ns/1ps
module rev_lsu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_store = 1'b0, req_rev = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [4:0]  req_rd = '0;
  logic        busy, mem_req, mem_we, done, wb_en, exc_valid, exc_align, exc_store;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [3:0]  mem_be;
  logic [4:0]  wb_idx, exc_rd;
  logic [1:0]  exc_mask;
  logic        mem_ack = 1'b0, mem_fault = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rev_lsu u_rev_lsu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_rev(req_rev), .req_addr(req_addr), .req_rd(req_rd),
    .req_wdata(req_wdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_fault(mem_fault), .mem_rdata(mem_rdata), .done(done), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data), .exc_valid(exc_valid), .exc_align(exc_align),
    .exc_store(exc_store), .exc_rd(exc_rd), .exc_mask(exc_mask)
  );

  // memory model: 64 bytes, big-endian, faults when address bit 31 is set
  logic [7:0]  mem_b [0:63];
  logic [7:0]  exp_b [0:63];
  int          lat_cfg = 0, cnt = 0, acks = 0;
  logic [31:0] last_addr = '0;
  logic [3:0]  last_be = '0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) cnt <= 0;
    else if (mem_req && !mem_ack) begin
      if (cnt >= lat_cfg) begin
        cnt       <= 0;
        mem_ack   <= 1'b1;
        acks      <= acks + 1;
        last_addr <= mem_addr;
        last_be   <= mem_be;
        if (mem_addr[31]) begin
          mem_fault <= 1'b1;
          mem_rdata <= 32'hDEADBEEF;
        end else begin
          mem_fault <= 1'b0;
          mem_rdata <= {mem_b[{mem_addr[5:2], 2'd0}], mem_b[{mem_addr[5:2], 2'd1}],
                        mem_b[{mem_addr[5:2], 2'd2}], mem_b[{mem_addr[5:2], 2'd3}]};
          if (mem_we) begin
            for (int i = 0; i < 4; i++) begin
              if (mem_be[i]) mem_b[{mem_addr[5:2], 2'(3 - i)}] <= mem_wdata[8*i +: 8];
            end
          end
        end
      end else cnt <= cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(input bit st, input int sz, input bit rv, input logic [31:0] addr,
                    input logic [4:0] rd, input logic [31:0] wd, input int lat, input bit poke);
    int fl, m, n, base, wbase, acks0, w;
    logic [31:0] phys, expv, gotw, expw;
    logic [3:0] ebe;
    bit flt, mis;
    fl    = rv ? (sz == 0 ? 3 : (sz == 1 ? 2 : 0)) : 0;
    m     = (sz == 0) ? 0 : (sz == 1 ? 1 : 3);
    n     = 1 << sz;
    phys  = addr ^ 32'(fl);
    base  = int'(phys[5:0]) & ~m;
    wbase = base & ~3;
    flt   = addr[31];
    mis   = !flt && sz > 0 && ((int'(phys[1:0]) & m) != 0);
    expv  = '0;
    for (int k = 0; k < n; k++) begin
      if (rv) expv = (expv << 8) | 32'(exp_b[base + n - 1 - k]);
      else    expv = (expv << 8) | 32'(exp_b[base + k]);
    end
    ebe = (sz == 0) ? (4'b1000 >> phys[1:0]) : (sz == 1 ? (phys[1] ? 4'b0011 : 4'b1100) : 4'b1111);
    lat_cfg = lat;
    acks0   = acks;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = 2'(sz); req_rev = rv;
    req_addr = addr; req_rd = rd; req_wdata = wd;
    @(negedge clk);
    if (poke) begin
      req_addr = addr ^ 32'h10; req_wdata = ~wd; req_store = !st;
    end else req_valid = 1'b0;
    chk(busy && mem_req, "R5", "busy after accept", {30'd0, busy, mem_req}, 32'd3);
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
    w = 0;
    while (!done && w < 60) begin
      @(negedge clk);
      w++;
    end
    chk(done == 1'b1, "R10", "done arrives", {31'd0, done}, 32'd1);
    chk(acks == acks0 + 1, "R5", "one memory access", 32'(acks - acks0), 32'd1);
    chk(last_addr == phys, "R3", "adjusted address", last_addr, phys);
    chk(last_be == ebe, "R2", "lane enables", {28'd0, last_be}, {28'd0, ebe});
    if (flt) begin
      chk(exc_valid && !exc_align && !wb_en, "R6", "fault reported",
          {29'd0, exc_valid, exc_align, wb_en}, 32'd4);
    end else if (mis) begin
      chk(exc_valid && exc_align && !wb_en && exc_rd == rd && exc_store == st &&
          exc_mask == 2'(m), "R7", "misalign report",
          {20'd0, exc_valid, exc_align, wb_en, exc_store, exc_rd, exc_mask},
          {20'd0, 1'b1, 1'b1, 1'b0, st, rd, 2'(m)});
    end else begin
      chk(!exc_valid, "R9", "no exception", {31'd0, exc_valid}, 32'd0);
      if (!st) begin
        if (rd != 0)
          chk(wb_en && wb_idx == rd && wb_data == expv, rv ? "R4" : "R2", "load value",
              wb_data, expv);
        else
          chk(!wb_en, "R8", "no writeback to r0", {31'd0, wb_en}, 32'd0);
      end
    end
    if (st && !flt) begin
      for (int k = 0; k < n; k++)
        exp_b[base + k] = rv ? wd[8*k +: 8] : wd[8*(n - 1 - k) +: 8];
    end
    if (st) begin
      gotw = {mem_b[wbase], mem_b[wbase + 1], mem_b[wbase + 2], mem_b[wbase + 3]};
      expw = {exp_b[wbase], exp_b[wbase + 1], exp_b[wbase + 2], exp_b[wbase + 3]};
      chk(gotw == expw, flt ? "R6" : (rv ? "R4" : "R2"), "stored word", gotw, expw);
    end
    @(negedge clk);
    chk(!done && !wb_en && !exc_valid, "R10", "single result cycle",
        {29'd0, done, wb_en, exc_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n_op;
    for (int j = 0; j < 64; j++) begin
      mem_b[j] = 8'(j * 7 + 3);
      exp_b[j] = 8'(j * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !done && !wb_en && !exc_valid, "R1", "reset state",
        {27'd0, busy, mem_req, done, wb_en, exc_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mem_req && !done, "R1", "after reset", {29'd0, busy, mem_req, done}, 32'd0);
    n_op = 0;
    // sweep of store/load x size x reverse x low address bits
    for (int st = 0; st < 2; st++)
      for (int sz = 0; sz < 3; sz++)
        for (int rv = 0; rv < 2; rv++)
          for (int a = 0; a < 4; a++) begin
            op(st[0], sz, rv[0], {26'd0, 4'(n_op), 2'(a)}, 5'(n_op % 7),
               32'hA1B2C3D4 ^ 32'(n_op * 32'h01010101), n_op % 3, 1'b0);
            n_op++;
          end
    // read back after stores, all variants
    for (int sz = 0; sz < 3; sz++)
      for (int rv = 0; rv < 2; rv++)
        for (int a = 0; a < 4; a++)
          op(1'b0, sz, rv[0], {26'd0, 4'(sz * 5 + a), 2'(a)}, 5'd9, '0, 1, 1'b0);
    // fault alone and fault together with misalignment (R6)
    op(1'b0, 2, 1'b0, 32'h8000_0004, 5'd3, '0, 2, 1'b0);
    op(1'b0, 1, 1'b0, 32'h8000_0005, 5'd3, '0, 1, 1'b0);
    op(1'b1, 2, 1'b1, 32'h8000_0006, 5'd4, 32'h1234_5678, 0, 1'b0);
    op(1'b1, 1, 1'b1, 32'h8000_0003, 5'd6, 32'h0000_ABCD, 2, 1'b0);
    // request raised while busy is ignored (R5)
    op(1'b0, 2, 1'b0, 32'h0000_0020, 5'd7, '0, 2, 1'b1);
    op(1'b1, 1, 1'b1, 32'h0000_0028, 5'd8, 32'h0000_5A6B, 3, 1'b1);
    op(1'b0, 1, 1'b1, 32'h0000_0028, 5'd8, '0, 0, 1'b0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule